// File: doc/BRIEF.md
# Output Driver Impedance Calibration Sequencer

This block sets the drive-strength codes of a multi-leg push-pull output driver. It holds two unsigned codes: one for the pull-up leg and one for the pull-down leg. An external analog comparator reports, for each leg, whether the leg is too weak and its code must rise. A start request begins the initial calibration. Both codes return to mid-scale. The sequencer then searches the pull-up code first, against the precision reference resistor. After that it searches the pull-down code, against the pull-up leg that is now calibrated. Each search step waits a fixed number of cycles for the comparator to settle and then moves the code by one. The search ends when the comparator reverses or when the code reaches a limit.

After the initial calibration the sequencer is in tracking mode. An interval counter is loaded from a configuration input. Once it has run out, the next refresh strobe makes an update eligible. An update moves each code by at most one step, in the direction its comparator indicates, and it takes effect in a single clock edge. No update is applied while read data is driven. An eligible update is held until the read-busy flag clears. Each time the codes are applied, a one-cycle strobe tells the driver to latch them.

Top module: `zqc_cal_ctrl`

## Requirements
- R1: After synchronous reset both codes read 32 (mid-scale of the 6-bit range), `cal_done` and `code_apply` are 0, and without `cal_start` nothing changes.
- R2: A `cal_start` in idle or tracking mode reloads both codes to 32 at the next edge and clears `cal_done`. The pull-up code is then searched using `cmp_pu_low`, and only after that the pull-down code using `cmp_pd_low`. A comparator value of 1 steps the code up and 0 steps it down.
- R3: The search of a leg keeps the first code at which the comparator's direction differs from the previous sample. It also stops, keeping the code, when the requested step would pass 0 or 63. With a comparator that reads 1 exactly when code < T, the result is min(T,63) for T > 32 and max(T-1,0) otherwise.
- R4: Each search sample takes 5 cycles (4 settling cycles and 1 evaluation cycle). `cal_done` rises exactly 5×(n_pu+n_pd) edges after the edge that accepts `cal_start`, where n = |final code − 32| + 1, and never more than 350 edges after it.
- R5: When the calibration completes, `cal_done` goes to 1. `code_apply` is 1 for exactly that one cycle.
- R6: The interval counter is reloaded from `ivl_cfg` when the calibration completes and at each update. It then counts down one per cycle. A refresh strobe that arrives before the counter reaches 0 is ignored.
- R7: In tracking mode, an eligible update with `rd_busy` low moves each code by one step toward its comparator's direction at the edge that samples it. `code_apply` is 1 in the cycle in which the new codes appear.
- R8: In a tracking update, a code at 63 asked to rise, or at 0 asked to fall, keeps its value, and `code_apply` still pulses.
- R9: While `rd_busy` is 1 no code changes and `code_apply` stays 0. An update that becomes eligible during that time is held and is applied at the first edge with `rd_busy` low.
- R10: A `cal_start` that arrives while a search is running is ignored, and the search timing and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Request for a full initial calibration |
| cmp_pu_low | input | 1 | Pull-up comparator: 1 = code must rise |
| cmp_pd_low | input | 1 | Pull-down comparator: 1 = code must rise |
| refresh_stb | input | 1 | One-cycle refresh command strobe |
| rd_busy | input | 1 | Read data is being driven on the bus |
| ivl_cfg | input | IVL_W | Update interval reload value in cycles |
| pu_code | output | CODE_W | Pull-up drive-strength code |
| pd_code | output | CODE_W | Pull-down drive-strength code |
| cal_done | output | 1 | Initial calibration complete |
| code_apply | output | 1 | One-cycle strobe: latch the codes |

## Verification
A refresh strobe can arrive in the same cycle as the read-busy flag, so an eligible update meets the read lockout. The bench raises the refresh strobe and `rd_busy` in one cycle after the interval has expired. It checks that the codes and the strobe stay still for as long as `rd_busy` is held. It then checks that the held update lands, one step in the comparator's direction, at the first edge after the flag drops. The same bench also puts an early refresh right behind an applied update, to confirm that the interval reload wins over the strobe.

// File: rtl/zqc_pkg.sv
package zqc_pkg;
  typedef enum logic [1:0] {
    ZS_IDLE,
    ZS_SETTLE,
    ZS_EVAL,
    ZS_TRACK
  } zq_state_e;

  localparam int unsigned LEG_PU   = 0;
  localparam int unsigned LEG_PD   = 1;
  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/zqc_code_reg.sv
module zqc_code_reg #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_mid,
  input  logic              step_en,
  input  logic              step_up,
  output logic [CODE_W-1:0] code,
  output logic              at_max,
  output logic              at_min
);
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_TOP = '1;

  assign at_max = (code == CODE_TOP);
  assign at_min = (code == '0);

  always_ff @(posedge clk) begin
    if (rst || load_mid) begin
      code <= CODE_MID;
    end else if (step_en) begin
      if (step_up && !at_max) begin
        code <= code + 1'b1;
      end else if (!step_up && !at_min) begin
        code <= code - 1'b1;
      end
    end
  end

  AST_CODE_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_mid)) |->
      (((int'(code) - int'($past(code))) <= 1) && ((int'(code) - int'($past(code))) >= -1))); // R7

  AST_CODE_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_mid) && $past(step_en) && $past(step_up) && ($past(code) == CODE_TOP))
      |-> (code == CODE_TOP)); // R8

  AST_CODE_SAT_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_mid) && $past(step_en) && !$past(step_up) && ($past(code) == '0))
      |-> (code == '0)); // R8
endmodule

// File: rtl/zqc_settle_timer.sv
module zqc_settle_timer #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == CW'(SETTLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/zqc_interval_timer.sv
module zqc_interval_timer #(
  parameter int unsigned IVL_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic [IVL_W-1:0] reload_val,
  output logic             expired
);
  logic [IVL_W-1:0] cnt_q;

  assign expired = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (reload) begin
      cnt_q <= reload_val;
    end else if (!expired) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_IVL_REARMED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reload) && ($past(reload_val) != '0)) |-> !expired); // R6
endmodule

// File: rtl/zqc_cal_ctrl.sv
module zqc_cal_ctrl
  import zqc_pkg::*;
#(
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned IVL_W      = 20,
  parameter int unsigned CAL_BUDGET = 350
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_start,
  input  logic              cmp_pu_low,
  input  logic              cmp_pd_low,
  input  logic              refresh_stb,
  input  logic              rd_busy,
  input  logic [IVL_W-1:0]  ivl_cfg,
  output logic [CODE_W-1:0] pu_code,
  output logic [CODE_W-1:0] pd_code,
  output logic              cal_done,
  output logic              code_apply
);
  localparam int unsigned BUD_W = $clog2(CAL_BUDGET + 1) + 1;

  zq_state_e state_q;
  logic      leg_q;
  logic      first_q;
  logic      dir_q;
  logic      done_q;
  logic      apply_q;
  logic      pend_q;

  logic [NUM_LEGS-1:0] cmp_v;
  logic [NUM_LEGS-1:0] step_en_v;
  logic [NUM_LEGS-1:0] at_max_v;
  logic [NUM_LEGS-1:0] at_min_v;
  logic [CODE_W-1:0]   code_v [NUM_LEGS];

  logic settle_done;
  logic ivl_expired;
  logic ivl_reload;
  logic cur_cmp;
  logic reverse;
  logic blocked;
  logic leg_stop;
  logic start_ok;
  logic eligible;
  logic upd;

  assign cmp_v    = {cmp_pd_low, cmp_pu_low};
  assign cur_cmp  = cmp_v[leg_q];
  assign reverse  = !first_q && (cur_cmp != dir_q);
  assign blocked  = cur_cmp ? at_max_v[leg_q] : at_min_v[leg_q];
  assign leg_stop = reverse || blocked;
  assign start_ok = cal_start && ((state_q == ZS_IDLE) || (state_q == ZS_TRACK));
  assign eligible = pend_q || (ivl_expired && refresh_stb);
  assign upd      = (state_q == ZS_TRACK) && !cal_start && eligible && !rd_busy;

  assign ivl_reload = ((state_q == ZS_EVAL) && leg_stop && (leg_q == 1'(LEG_PD))) || upd;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    assign step_en_v[g] = ((state_q == ZS_EVAL) && !leg_stop && (leg_q == 1'(g))) || upd;

    zqc_code_reg #(.CODE_W(CODE_W)) u_code (
      .clk      (clk),
      .rst      (rst),
      .load_mid (start_ok),
      .step_en  (step_en_v[g]),
      .step_up  (cmp_v[g]),
      .code     (code_v[g]),
      .at_max   (at_max_v[g]),
      .at_min   (at_min_v[g])
    );
  end

  zqc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ZS_SETTLE),
    .done (settle_done)
  );

  zqc_interval_timer #(.IVL_W(IVL_W)) u_ivl (
    .clk        (clk),
    .rst        (rst),
    .reload     (ivl_reload),
    .reload_val (ivl_cfg),
    .expired    (ivl_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ZS_IDLE;
      leg_q   <= 1'(LEG_PU);
      first_q <= 1'b1;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      apply_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      apply_q <= 1'b0;
      if (start_ok) begin
        state_q <= ZS_SETTLE;
        leg_q   <= 1'(LEG_PU);
        first_q <= 1'b1;
        done_q  <= 1'b0;
        pend_q  <= 1'b0;
      end else begin
        case (state_q)
          ZS_SETTLE: begin
            if (settle_done) state_q <= ZS_EVAL;
          end
          ZS_EVAL: begin
            if (leg_stop) begin
              if (leg_q == 1'(LEG_PU)) begin
                leg_q   <= 1'(LEG_PD);
                first_q <= 1'b1;
                state_q <= ZS_SETTLE;
              end else begin
                state_q <= ZS_TRACK;
                done_q  <= 1'b1;
                apply_q <= 1'b1;
                pend_q  <= 1'b0;
              end
            end else begin
              dir_q   <= cur_cmp;
              first_q <= 1'b0;
              state_q <= ZS_SETTLE;
            end
          end
          ZS_TRACK: begin
            if (upd) begin
              apply_q <= 1'b1;
              pend_q  <= 1'b0;
            end else if (eligible) begin
              pend_q  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pu_code    = code_v[LEG_PU];
  assign pd_code    = code_v[LEG_PD];
  assign cal_done   = done_q;
  assign code_apply = apply_q;

  logic [BUD_W-1:0] cal_cyc_q;
  always_ff @(posedge clk) begin
    if (rst || (state_q == ZS_IDLE) || (state_q == ZS_TRACK)) begin
      cal_cyc_q <= '0;
    end else if (cal_cyc_q != '1) begin
      cal_cyc_q <= cal_cyc_q + 1'b1;
    end
  end

  AST_CAL_BUDGET: assert property (@(posedge clk) disable iff (rst)
    (cal_cyc_q < BUD_W'(CAL_BUDGET))); // R4

  AST_HOLD_DURING_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (state_q == ZS_TRACK) && ($past(state_q) == ZS_TRACK) && $past(rd_busy))
      |-> ($stable(pu_code) && $stable(pd_code) && !code_apply)); // R9

  AST_DONE_APPLY_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_done) |-> code_apply); // R5
endmodule

// File: tb/zqc_cal_ctrl_tb.sv
module zqc_cal_ctrl_tb;
  localparam int CODE_W = 6;
  localparam int IVL_W  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_start = 1'b0;
  logic refresh_stb = 1'b0;
  logic rd_busy = 1'b0;
  logic [IVL_W-1:0] ivl_cfg = IVL_W'(6);
  logic [CODE_W-1:0] pu_code, pd_code;
  logic cal_done, code_apply;
  logic cmp_pu_low, cmp_pd_low;

  int tgt_pu = 32;
  int tgt_pd = 32;
  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  // comparator model: leg too weak while the code is below its target
  assign cmp_pu_low = (int'(pu_code) < tgt_pu);
  assign cmp_pd_low = (int'(pd_code) < tgt_pd);

  zqc_cal_ctrl u_dut (
    .clk(clk), .rst(rst), .cal_start(cal_start), .cmp_pu_low(cmp_pu_low),
    .cmp_pd_low(cmp_pd_low), .refresh_stb(refresh_stb), .rd_busy(rd_busy),
    .ivl_cfg(ivl_cfg), .pu_code(pu_code), .pd_code(pd_code),
    .cal_done(cal_done), .code_apply(code_apply)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int t);
    if (t > 32) return (t > 63) ? 63 : t;
    return (t < 1) ? 0 : t - 1;
  endfunction

  function automatic int absd(input int a);
    return (a < 0) ? -a : a;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // full calibration; returns edges from start acceptance to done
  task automatic run_cal(input int tp, input int td, input bit poke);
    int cyc;
    int e_pu, e_pd, exp_cyc;
    tgt_pu = tp;
    tgt_pd = td;
    e_pu = exp_code(tp);
    e_pd = exp_code(td);
    exp_cyc = 5 * (absd(e_pu - 32) + 1 + absd(e_pd - 32) + 1);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    chk("R2 restart pu mid", int'(pu_code), 32);
    chk("R2 restart pd mid", int'(pd_code), 32);
    chk("R2 done cleared", int'(cal_done), 0);
    cyc = 0;
    while (!cal_done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 5) cal_start = 1'b1;   // R10 start during search
      else cal_start = 1'b0;
    end
    cal_start = 1'b0;
    chk("R4 exact duration", cyc, exp_cyc);
    chk("R4 budget", int'(cyc <= 350), 1);
    chk("R3 pu result", int'(pu_code), e_pu);
    chk("R3 pd result", int'(pd_code), e_pd);
    chk("R5 apply on done", int'(code_apply), 1);
    @(negedge clk);
    chk("R5 apply single cycle", int'(code_apply), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pu reset", int'(pu_code), 32);
    chk("R1 pd reset", int'(pd_code), 32);
    chk("R1 done reset", int'(cal_done), 0);
    chk("R1 apply reset", int'(code_apply), 0);
    refresh_stb = 1'b1;
    repeat (10) @(negedge clk);
    refresh_stb = 1'b0;
    chk("R1 idle stays", int'(cal_done), 0);
    chk("R1 idle code", int'(pu_code), 32);

    // sweep every pull-up target; pull-down targets spread across the range
    for (int t = 0; t <= 64; t++) begin
      run_cal(t, (t * 23 + 11) % 65, (t % 8) == 3);
    end

    // tracking mode, interval 6
    run_cal(50, 20, 1'b0);
    refresh_stb = 1'b1;
    @(negedge clk);
    refresh_stb = 1'b0;
    chk("R6 early refresh pu", int'(pu_code), 50);
    chk("R6 early refresh pd", int'(pd_code), 19);
    chk("R6 early refresh apply", int'(code_apply), 0);
    repeat (8) @(negedge clk);
    tgt_pu = 60;
    tgt_pd = 0;
    refresh_stb = 1'b1;
    @(negedge clk);
    chk("R7 update pu up", int'(pu_code), 51);
    chk("R7 update pd down", int'(pd_code), 18);
    chk("R7 apply", int'(code_apply), 1);
    @(negedge clk);
    refresh_stb = 1'b0;
    chk("R6 refresh after reload pu", int'(pu_code), 51);
    chk("R6 refresh after reload apply", int'(code_apply), 0);
    repeat (8) @(negedge clk);
    rd_busy = 1'b1;
    refresh_stb = 1'b1;
    @(negedge clk);
    refresh_stb = 1'b0;
    chk("R9 locked pu", int'(pu_code), 51);
    chk("R9 locked apply", int'(code_apply), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held pd", int'(pd_code), 18);
      chk("R9 held apply", int'(code_apply), 0);
    end
    rd_busy = 1'b0;
    @(negedge clk);
    chk("R9 released pu", int'(pu_code), 52);
    chk("R9 released pd", int'(pd_code), 17);
    chk("R9 released apply", int'(code_apply), 1);
    @(negedge clk);
    chk("R9 released single", int'(code_apply), 0);

    // saturation during tracking
    run_cal(64, 0, 1'b0);
    repeat (8) @(negedge clk);
    refresh_stb = 1'b1;
    @(negedge clk);
    refresh_stb = 1'b0;
    chk("R8 pu stays top", int'(pu_code), 63);
    chk("R8 pd stays bottom", int'(pd_code), 0);
    chk("R8 apply pulses", int'(code_apply), 1);

    finish_run();
  end
endmodule